// File: doc/BRIEF.md
# CAN Bit-Time Quanta Generator

This block derives the nominal bit timing of a CAN controller from its protocol clock. A programmable prescaler divides the clock into time quanta. Each bit is then built from quanta in a fixed order: one synchronisation quantum, then a first segment that covers both propagation and phase-1 time, then a phase-2 segment. The two segment lengths are programmable.

The block produces four outputs. A one-clock tick marks the last clock of each quantum. A two-bit indicator names the current segment. A one-clock sample strobe marks the end of the first segment, and a one-clock strobe marks the end of each bit. Surrounding logic uses the sample strobe to capture the bus level and the bit strobe to advance the bit stream. The configuration can be changed while the block runs. A new value is taken up only at a bit boundary, so a bit in progress is never cut short or stretched.

Top module: `can_bit_timer`

## Requirements
- R1: With `en` high, `tq_tick` is high in exactly one clock out of every `presc` clocks. Counting the first clock with `en` high as cycle 0, the first tick falls in cycle `presc`-1.
- R2: One bit lasts `presc` * (1 + `tseg1_len` + `tseg2_len`) clocks, and bits repeat back to back while `en` stays high.
- R3: `seg` reads 0 during the first quantum of a bit (sync). It reads 1 during the next `tseg1_len` quanta and 2 during the final `tseg2_len` quanta. The value 3 never occurs.
- R4: `sample_pt` is high for exactly one clock per bit. That clock is the last clock of the last quantum with `seg` = 1.
- R5: `bit_end` is high for exactly one clock per bit. That clock is the last clock of the last quantum with `seg` = 2. In the clock that follows, `seg` is 0.
- R6: The full legal ranges work: `presc` from 1 (one quantum per clock, tick high every clock) to 64, `tseg1_len` from 1 to 16 and `tseg2_len` from 1 to 8.
- R7: A configuration change made while `en` is high has no effect on the current bit. The new values apply from the clock after the next `bit_end`.
- R8: While `en` is low, `tq_tick`, `sample_pt` and `bit_end` are low and `seg` is 0, starting in the same clock. When `en` rises again, timing restarts from the start of a sync quantum, as in R1.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Protocol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds all counters at zero |
| presc | input | 7 | Clocks per time quantum, 1 to 64 |
| tseg1_len | input | 5 | First segment length in quanta, 1 to 16 |
| tseg2_len | input | 4 | Second segment length in quanta, 1 to 8 |
| tq_tick | output | 1 | High on the last clock of each quantum |
| seg | output | 2 | Current segment: 0 sync, 1 first, 2 second |
| sample_pt | output | 1 | High on the last clock of the first segment |
| bit_end | output | 1 | High on the last clock of each bit |

## Verification
All four outputs are decoded directly from the registered counters and the live enable. An event due in cycle k after `en` rises is therefore visible during cycle k itself, with no added delay. A disable shows at the outputs in the same cycle. The bench changes its inputs just after a rising edge and samples at the following falling edge. Its expected values come from a closed-form division of the cycle index by the prescaler and by the bit length. For the mid-run configuration test, the bench expects the old timing up to and including the first `bit_end`, and the new timing from the next cycle.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PW  = 7,
  parameter int T1W = 5,
  parameter int T2W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [PW-1:0]  presc,
  input  logic [T1W-1:0] tseg1_len,
  input  logic [T2W-1:0] tseg2_len,
  output logic           tq_tick,
  output logic [1:0]     seg,
  output logic           sample_pt,
  output logic           bit_end
);
  localparam int QW = (T1W > T2W) ? T1W : T2W;
  localparam logic [1:0] S_SYNC = 2'd0, S_ONE = 2'd1, S_TWO = 2'd2;

  logic [PW-1:0]  p_q, pc;
  logic [T1W-1:0] t1_q;
  logic [T2W-1:0] t2_q;
  logic [QW-1:0]  qc;
  logic [1:0]     seg_q;
  logic           run, last1, last2;

  assign run       = en && rst_n;
  assign last1     = (qc == QW'(t1_q - T1W'(1)));
  assign last2     = (qc == QW'(t2_q - T2W'(1)));
  assign tq_tick   = run && (pc == p_q - PW'(1));
  assign sample_pt = tq_tick && (seg_q == S_ONE) && last1;
  assign bit_end   = tq_tick && (seg_q == S_TWO) && last2;
  assign seg       = run ? seg_q : S_SYNC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q   <= PW'(1);
      t1_q  <= T1W'(1);
      t2_q  <= T2W'(1);
      pc    <= '0;
      qc    <= '0;
      seg_q <= S_SYNC;
    end else if (!en) begin
      p_q   <= presc;
      t1_q  <= tseg1_len;
      t2_q  <= tseg2_len;
      pc    <= '0;
      qc    <= '0;
      seg_q <= S_SYNC;
    end else begin
      pc <= tq_tick ? '0 : pc + PW'(1);
      if (bit_end) begin
        p_q  <= presc;
        t1_q <= tseg1_len;
        t2_q <= tseg2_len;
      end
      if (tq_tick) begin
        case (seg_q)
          S_SYNC: begin
            seg_q <= S_ONE;
            qc    <= '0;
          end
          S_ONE: begin
            if (last1) begin
              seg_q <= S_TWO;
              qc    <= '0;
            end else begin
              qc <= qc + QW'(1);
            end
          end
          default: begin
            if (last2) begin
              seg_q <= S_SYNC;
              qc    <= '0;
            end else begin
              qc <= qc + QW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

module can_bit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       tq_tick,
  input logic [1:0] seg,
  input logic       sample_pt,
  input logic       bit_end
);
  a_r3_no_seg3: assert property (@(posedge clk) disable iff (!rst_n) seg != 2'd3);
  a_r4_sample_in_seg1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> (tq_tick && seg == 2'd1));
  a_r5_end_in_seg2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (tq_tick && seg == 2'd2 && !sample_pt));
  a_r5_restart_sync: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> seg == 2'd0);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tq_tick && !sample_pt && !bit_end && seg == 2'd0));
  a_r3_seg_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && seg != $past(seg)) |-> $past(tq_tick));
endmodule

bind can_bit_timer can_bit_timer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tq_tick(tq_tick),
  .seg(seg), .sample_pt(sample_pt), .bit_end(bit_end)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic clk = 0, rst_n = 0, en = 0;
  logic [6:0] presc = 7'd1;
  logic [4:0] tseg1_len = 5'd1;
  logic [3:0] tseg2_len = 4'd1;
  logic tq_tick, sample_pt, bit_end;
  logic [1:0] seg;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .tseg1_len(tseg1_len),
    .tseg2_len(tseg2_len), .tq_tick(tq_tick), .seg(seg), .sample_pt(sample_pt),
    .bit_end(bit_end)
  );

  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{1, 1, 1}, '{2, 3, 2}, '{3, 16, 8}, '{64, 1, 1}, '{1, 16, 8}, '{5, 4, 3}
  };

  task automatic check(string req, logic [4:0] act, logic [4:0] exp, int k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b (tick,seg,sample,end)", req, k, act, exp);
    end
  endtask

  function automatic logic [4:0] model(int k, int p, int t1, int t2);
    int q, r, len, qb;
    logic tk, sp, be;
    logic [1:0] s;
    q = k / p; r = k % p; len = 1 + t1 + t2; qb = q % len;
    tk = (r == p - 1);
    s = (qb == 0) ? 2'd0 : (qb <= t1) ? 2'd1 : 2'd2;
    sp = tk && (qb == t1);
    be = tk && (qb == len - 1);
    return {tk, s, sp, be};
  endfunction

  function automatic logic [4:0] outs();
    return {tq_tick, seg, sample_pt, bit_end};
  endfunction

  task automatic start(int p, int t1, int t2);
    @(posedge clk); #1;
    en = 0; presc = 7'(p); tseg1_len = 5'(t1); tseg2_len = 4'(t2);
    @(posedge clk); #1;
    en = 1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9: outputs low under reset, even with en high
    en = 1;
    repeat (3) @(negedge clk);
    check("R9", outs(), 5'b0, 0);
    @(posedge clk); #1;
    en = 0; rst_n = 1;
    @(negedge clk);
    check("R8", outs(), 5'b0, 0);

    // R1 R2 R3 R4 R5 R6: table walk, two bits per configuration
    for (int v = 0; v < NV; v++) begin
      int p, t1, t2, len;
      p = VEC[v][0]; t1 = VEC[v][1]; t2 = VEC[v][2];
      len = p * (1 + t1 + t2);
      start(p, t1, t2);
      for (int k = 0; k < 2 * len; k++) begin
        @(negedge clk);
        check((p == 1 || p == 64 || t1 == 16) ? "R6" : "R2", outs(), model(k, p, t1, t2), k);
      end
    end

    // R7: change config mid-bit; old timing until first bit_end at 11
    start(2, 3, 2);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R7", outs(), model(k, 2, 3, 2), k);
      if (k == 4) begin
        presc = 7'd1; tseg1_len = 5'd1; tseg2_len = 4'd1;
      end
    end
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      check("R7", outs(), model(k, 1, 1, 1), k + 12);
    end

    // R8: drop enable mid-bit, outputs quiet at once, restart from sync
    start(3, 2, 2);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R8", outs(), model(k, 3, 2, 2), k);
    end
    en = 0;
    #1;
    check("R8", outs(), 5'b0, 8);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8", outs(), 5'b0, 9 + k);
    end
    @(posedge clk); #1;
    en = 1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      check("R1", outs(), model(k, 3, 2, 2), k);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule